// File: doc/BRIEF.md
# SPI Receive Status Flags

This block keeps the receive-side status of a serial peripheral interface. It also holds the one-entry buffer that the CPU reads received bytes from. The shift engine sends a one-cycle pulse for each completed byte, together with that byte. The block decides whether the byte goes into the buffer or is lost to an overrun. It then raises the receive-full or overrun flag to match.

The CPU sees the flags through an 8-bit status/control byte. That byte also carries four writable control bits, a mode-fault input bit and a transmitter-empty bit. A flag is cleared by a two-step handshake: first a status read that sees the flag at 1, then a read of the data buffer. Each flag keeps its own record of whether it has been seen.

Two interrupt requests are produced. One is for receive-full and is gated by an external enable. The other is for errors, covers overrun or mode fault, and is gated by the error-enable control bit. Both are combinational, so each drops in the same cycle as the flag behind it.

Top module: `spi_rx_flags`

## Requirements
- R1: Synchronous active-low reset makes the status byte 0x08 (only the transmitter-empty bit, bit 3, at 1), clears the data buffer to 0 and deasserts both interrupt requests.
- R2: A `byte_done` pulse while the receive-full flag (status bit 7) is 0 loads `byte_in` into `data_q` and sets bit 7, both visible one cycle after the pulse.
- R3: A `byte_done` pulse while bit 7 is 1, and no clearing data read happens in that cycle, sets the overrun flag (status bit 5). `data_q` keeps its old byte and the new byte is dropped.
- R4: Bit 7 clears only by a data read that follows a status read which saw bit 7 at 1. A data read without that earlier status read leaves bit 7 unchanged.
- R5: Bit 5 clears by the same two-step handshake, armed separately. A status read taken while bit 5 was 0 does not let a later data read clear it.
- R6: If a `byte_done` pulse and a clearing data read fall in the same cycle, bit 7 stays 1, the new byte is loaded, bit 5 is not set, and the handshake must be repeated before bit 7 can clear.
- R7: `rx_irq` equals status bit 7 AND `rx_ie`, combinationally. It deasserts in the cycle bit 7 clears.
- R8: `err_irq` equals the error-enable bit (status bit 6) AND (bit 5 OR the mode-fault bit 4). With bit 6 at 0 it stays low.
- R9: A `ctl_wr` writes `ctl_wdata` bits 6, 2, 1 and 0 into the status byte. Bits 7, 5, 4 and 3 ignore writes. Bit 4 always shows the `mode_fault` input and bit 3 stays 1.
- R10: A status read taken while bit 7 is 0 does not arm its clear. A byte arriving later, followed by a data read, leaves bit 7 at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_done | input | 1 | One-cycle pulse: a full byte left the shift engine |
| byte_in | input | DATA_W | Byte delivered with `byte_done` |
| stat_rd | input | 1 | Bus read strobe of the status/control byte |
| data_rd | input | 1 | Bus read strobe of the receive data buffer |
| ctl_wr | input | 1 | Bus write strobe of the status/control byte |
| ctl_wdata | input | 8 | Write data for the status/control byte |
| rx_ie | input | 1 | Receive-full interrupt enable |
| mode_fault | input | 1 | Mode-fault flag from outside |
| data_q | output | DATA_W | Receive data buffer |
| stat_q | output | 8 | Packed status/control byte |
| rx_irq | output | 1 | Receive-full interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The clearing handshake is tried in several orders: a data read with no status read before it, a status read then a data read, a status read taken while the flag was still 0, and a status read that sees only one of the two flags. These orders tell a correctly armed clear apart from one that triggers on any data read, or one that shares a single armed bit between both flags. Bytes are sent into an empty buffer, into a full buffer, and in the same cycle as a clearing read. Comparing the resulting data and overrun bit separates "keep the old byte" from "overwrite", and separates a real overrun from a collision. Writes of all-ones and all-zeros show which status bits are writable.

// File: rtl/spi_rx_pkg.sv
// Package spi_rx_pkg
// Shared bit positions and control-field type for the receive status block.
// Assumes an 8-bit status/control byte whose layout is fixed by software.
package spi_rx_pkg;
    localparam int STAT_W      = 8;
    localparam int B_FULL      = 7;
    localparam int B_ERR_IE    = 6;
    localparam int B_OVR       = 5;
    localparam int B_MFAULT    = 4;
    localparam int B_TX_EMPTY  = 3;
    localparam int B_MF_EN     = 2;
    localparam int B_RATE_HI   = 1;
    localparam int B_RATE_LO   = 0;
    localparam int FLAG_N      = 2;
    localparam int F_FULL      = 0;
    localparam int F_OVR       = 1;

    typedef struct packed {
        logic       err_ie;
        logic       mf_en;
        logic [1:0] rate;
    } ctl_t;
endpackage

// File: rtl/rx_flag_cell.sv
// Module rx_flag_cell
// One sticky status flag with a two-step clear: a status read that sees the
// flag at 1 arms it, and a later data read clears flag and arm together.
// A set request in the clearing cycle wins, so the flag stays 1.
// Assumes the strobes are single-cycle and synchronous to clk.
module rx_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic data_rd_i,
    output logic flag_o,
    output logic clear_o
);
    logic flag_q;
    logic armed_q;

    // Clear fires when the data read follows an armed status read.
    always_comb clear_o = data_rd_i && armed_q;

    // Flag register: set has priority over the clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (set_i)    flag_q <= 1'b1;
        else if (clear_o)  flag_q <= 1'b0;
    end

    // Arm register: armed by a status read that observes the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)                      armed_q <= 1'b0;
        else if (clear_o)                armed_q <= 1'b0;
        else if (stat_rd_i && flag_q)    armed_q <= 1'b1;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/rx_data_buf.sv
// Module rx_data_buf
// Single-entry receive data buffer, loaded only when told to.
// Assumes the caller already blocked loads that would be overruns.
module rx_data_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] buf_q;

    // Capture the incoming byte when a load is granted.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_q <= '0;
        else if (load_i) buf_q <= byte_i;
    end

    assign data_o = buf_q;
endmodule

// File: rtl/rx_ctl_reg.sv
// Module rx_ctl_reg
// Writable control bits of the status/control byte, plus the
// transmitter-empty bit, held as a register that resets to 1.
// Assumes write data uses the status byte bit positions.
module rx_ctl_reg
    import spi_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [STAT_W-1:0] wdata_i,
    output ctl_t              ctl_o,
    output logic              tx_empty_o
);
    ctl_t ctl_q;
    logic tx_empty_q;

    // Update only the writable fields on a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_i) begin
            ctl_q.err_ie <= wdata_i[B_ERR_IE];
            ctl_q.mf_en  <= wdata_i[B_MF_EN];
            ctl_q.rate   <= {wdata_i[B_RATE_HI], wdata_i[B_RATE_LO]};
        end
    end

    // Transmitter-empty bit: reset to 1, not writable from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_empty_q <= 1'b1;
        else        tx_empty_q <= tx_empty_q;
    end

    assign ctl_o      = ctl_q;
    assign tx_empty_o = tx_empty_q;
endmodule

// File: rtl/spi_rx_flags.sv
// Module spi_rx_flags
// Receive-side status of a serial peripheral interface: the data buffer,
// receive-full and overrun flags with two-step clears, the packed
// status/control byte and two interrupt requests.
// Assumes byte_done is a one-cycle pulse and the bus strobes are one cycle.
module spi_rx_flags
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              ctl_wr,
    input  logic [STAT_W-1:0] ctl_wdata,
    input  logic              rx_ie,
    input  logic              mode_fault,
    output logic [DATA_W-1:0] data_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              rx_irq,
    output logic              err_irq
);
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flag_val;
    logic [FLAG_N-1:0] flag_clr;
    logic              overrun_now;
    logic              load_now;
    ctl_t              ctl;
    logic              tx_empty;

    // Overrun when the buffer is full and is not being emptied this cycle.
    always_comb begin
        overrun_now        = byte_done && flag_val[F_FULL] && !flag_clr[F_FULL];
        load_now           = byte_done && !overrun_now;
        flag_set[F_FULL]   = load_now;
        flag_set[F_OVR]    = overrun_now;
    end

    // One flag cell per sticky flag, each with its own arm bit.
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        rx_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (flag_set[i]),
            .stat_rd_i (stat_rd),
            .data_rd_i (data_rd),
            .flag_o    (flag_val[i]),
            .clear_o   (flag_clr[i])
        );
    end

    rx_data_buf #(.DATA_W(DATA_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_now),
        .byte_i (byte_in),
        .data_o (data_q)
    );

    rx_ctl_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ctl_wr),
        .wdata_i    (ctl_wdata),
        .ctl_o      (ctl),
        .tx_empty_o (tx_empty)
    );

    // Pack the status/control byte at its software-visible positions.
    always_comb begin
        stat_q               = '0;
        stat_q[B_FULL]       = flag_val[F_FULL];
        stat_q[B_ERR_IE]     = ctl.err_ie;
        stat_q[B_OVR]        = flag_val[F_OVR];
        stat_q[B_MFAULT]     = mode_fault;
        stat_q[B_TX_EMPTY]   = tx_empty;
        stat_q[B_MF_EN]      = ctl.mf_en;
        stat_q[B_RATE_HI]    = ctl.rate[1];
        stat_q[B_RATE_LO]    = ctl.rate[0];
    end

    // Interrupt requests: flag AND enable, no register stage.
    always_comb begin
        rx_irq  = flag_val[F_FULL] && rx_ie;
        err_irq = ctl.err_ie && (flag_val[F_OVR] || mode_fault);
    end
endmodule

// File: rtl/spi_rx_flags_chk.sv
// Module spi_rx_flags_chk
// Port-level checker bound to spi_rx_flags; observes only its ports.
// Assumes the same clock and synchronous active-low reset as the design.
module spi_rx_flags_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_done,
    input logic [DATA_W-1:0] byte_in,
    input logic              data_rd,
    input logic              ctl_wr,
    input logic              rx_ie,
    input logic [DATA_W-1:0] data_q,
    input logic [7:0]        stat_q,
    input logic              rx_irq,
    input logic              err_irq
);
    assert_load_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !stat_q[7]) |=> (stat_q[7] && data_q == $past(byte_in)));

    assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && stat_q[7] && !data_rd) |=> (stat_q[5] && $stable(data_q)));

    assert_full_clear_by_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[7]) |-> $past(data_rd));

    assert_ovr_clear_by_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[5]) |-> $past(data_rd));

    assert_rx_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (stat_q[7] && rx_ie));

    assert_err_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (stat_q[6] && (stat_q[5] || stat_q[4])));

    assert_tx_empty_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> stat_q[3]);
endmodule

bind spi_rx_flags spi_rx_flags_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_done (byte_done),
    .byte_in   (byte_in),
    .data_rd   (data_rd),
    .ctl_wr    (ctl_wr),
    .rx_ie     (rx_ie),
    .data_q    (data_q),
    .stat_q    (stat_q),
    .rx_irq    (rx_irq),
    .err_irq   (err_irq)
);

// File: tb/spi_rx_flags_test.sv
`timescale 1ns/1ps
// Bench for spi_rx_flags: a vector table walked by one loop, then directed
// tests for reset and for the ordering corner cases of the clear handshake.
module spi_rx_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_done = 1'b0;
    logic [7:0] byte_in = '0;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       rx_ie = 1'b0;
    logic       mode_fault = 1'b0;
    logic [7:0] data_q;
    logic [7:0] stat_q;
    logic       rx_irq;
    logic       err_irq;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spi_rx_flags uut (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_in(byte_in),
        .stat_rd(stat_rd), .data_rd(data_rd), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .rx_ie(rx_ie), .mode_fault(mode_fault),
        .data_q(data_q), .stat_q(stat_q), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    typedef struct packed {
        logic       bd;
        logic [7:0] b;
        logic       sr;
        logic       dr;
        logic       cw;
        logic [7:0] wd;
        logic       ie;
        logic       mf;
        logic [7:0] es;
        logic [7:0] ed;
        logic       eri;
        logic       eei;
    } vec_t;

    localparam int NVEC = 14;
    // bd, byte, stat_rd, data_rd, ctl_wr, wdata, rx_ie, mode_fault | stat, data, rx_irq, err_irq
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h08,8'h00,1'b0,1'b0}, // R1 idle after reset
        '{1'b1,8'hA5,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h88,8'hA5,1'b0,1'b0}, // R2 load into empty
        '{1'b0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0, 8'h88,8'hA5,1'b1,1'b0}, // R7 enable raises rx_irq
        '{1'b0,8'h00,1'b0,1'b1,1'b0,8'h00,1'b1,1'b0, 8'h88,8'hA5,1'b1,1'b0}, // R4 data read alone
        '{1'b0,8'h00,1'b1,1'b0,1'b0,8'h00,1'b1,1'b0, 8'h88,8'hA5,1'b1,1'b0}, // R4 status read arms
        '{1'b0,8'h00,1'b0,1'b1,1'b0,8'h00,1'b1,1'b0, 8'h08,8'hA5,1'b0,1'b0}, // R4 R7 clears, irq drops
        '{1'b1,8'h3C,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h88,8'h3C,1'b0,1'b0}, // R2 second byte
        '{1'b1,8'h77,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 8'hA8,8'h3C,1'b0,1'b0}, // R3 overrun keeps 3C
        '{1'b0,8'h00,1'b0,1'b0,1'b1,8'hFF,1'b0,1'b0, 8'hEF,8'h3C,1'b0,1'b1}, // R9 R8 write all-ones
        '{1'b0,8'h00,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0, 8'hEF,8'h3C,1'b0,1'b1}, // R5 arm both flags
        '{1'b0,8'h00,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0, 8'h4F,8'h3C,1'b0,1'b0}, // R4 R5 both clear
        '{1'b0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b0,1'b1, 8'h5F,8'h3C,1'b0,1'b1}, // R8 mode fault
        '{1'b0,8'h00,1'b0,1'b0,1'b1,8'h00,1'b0,1'b1, 8'h18,8'h3C,1'b0,1'b0}, // R9 R8 write zeros
        '{1'b0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h08,8'h3C,1'b0,1'b0}  // R9 bit 4 follows input
    };

    task automatic drive(input logic bd, input logic [7:0] b, input logic sr,
                         input logic dr, input logic cw, input logic [7:0] wd,
                         input logic ie, input logic mf);
        @(negedge clk);
        byte_done = bd; byte_in = b; stat_rd = sr; data_rd = dr;
        ctl_wr = cw; ctl_wdata = wd; rx_ie = ie; mode_fault = mf;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] es, input logic [7:0] ed,
                         input logic eri, input logic eei);
        n_vec++;
        if (stat_q !== es || data_q !== ed || rx_irq !== eri || err_irq !== eei) begin
            n_bad++;
            $display("FAIL %s: stat=%h data=%h rx_irq=%b err_irq=%b, expected stat=%h data=%h rx_irq=%b err_irq=%b",
                     req, stat_q, data_q, rx_irq, err_irq, es, ed, eri, eei);
        end
    endtask

    task automatic step(input string req, input logic bd, input logic [7:0] b,
                        input logic sr, input logic dr, input logic [7:0] es,
                        input logic [7:0] ed);
        drive(bd, b, sr, dr, 1'b0, 8'h00, 1'b0, 1'b0);
        check(req, es, ed, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", 8'h08, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].bd, VEC[i].b, VEC[i].sr, VEC[i].dr, VEC[i].cw,
                  VEC[i].wd, VEC[i].ie, VEC[i].mf);
            check($sformatf("table vector %0d", i), VEC[i].es, VEC[i].ed,
                  VEC[i].eri, VEC[i].eei);
        end

        // R6: byte arrives in the same cycle as the clearing data read.
        step("R6 load", 1'b1, 8'h11, 1'b0, 1'b0, 8'h88, 8'h11);
        step("R6 arm", 1'b0, 8'h00, 1'b1, 1'b0, 8'h88, 8'h11);
        step("R6 collision keeps flag", 1'b1, 8'hC3, 1'b0, 1'b1, 8'h88, 8'hC3);
        step("R6 arm consumed", 1'b0, 8'h00, 1'b0, 1'b1, 8'h88, 8'hC3);
        step("R6 rearm", 1'b0, 8'h00, 1'b1, 1'b0, 8'h88, 8'hC3);
        step("R6 clear", 1'b0, 8'h00, 1'b0, 1'b1, 8'h08, 8'hC3);

        // R5: status read that saw only the full flag must not clear overrun.
        step("R5 load", 1'b1, 8'h21, 1'b0, 1'b0, 8'h88, 8'h21);
        step("R5 arm full only", 1'b0, 8'h00, 1'b1, 1'b0, 8'h88, 8'h21);
        step("R5 overrun", 1'b1, 8'h22, 1'b0, 1'b0, 8'hA8, 8'h21);
        step("R5 overrun survives", 1'b0, 8'h00, 1'b0, 1'b1, 8'h28, 8'h21);
        step("R5 arm overrun", 1'b0, 8'h00, 1'b1, 1'b0, 8'h28, 8'h21);
        step("R5 overrun clears", 1'b0, 8'h00, 1'b0, 1'b1, 8'h08, 8'h21);

        // R10: status read while empty does not arm.
        step("R10 read while empty", 1'b0, 8'h00, 1'b1, 1'b0, 8'h08, 8'h21);
        step("R10 load", 1'b1, 8'h5A, 1'b0, 1'b0, 8'h88, 8'h5A);
        step("R10 flag kept", 1'b0, 8'h00, 1'b0, 1'b1, 8'h88, 8'h5A);

        // R1: reset in mid-run returns everything to the reset state.
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0);
        check("R1 pre-reset state", 8'hCF, 8'h5A, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        ctl_wr = 1'b0;
        rx_ie = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", 8'h08, 8'h00, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule